// File: doc/BRIEF.md
# Host-to-Core Mailbox Bridge With Vector Command

This block joins a small host controller to a signal-processing core. Words from the host land in a downlink queue that the core drains. Words from the core land in a smaller uplink queue that the host drains. The downlink queue holds eight words and the uplink queue holds four. The core owns a pair of signal flags that the host can see, and each flag can raise a host interrupt when its enable is set. The host can also post a command vector. The bridge holds that vector number and keeps an interrupt request to the core raised until the core acknowledges it. This lets the host force any vectored interrupt on the core.

Each queue port is valid/ready. A write beat is taken when valid and ready are both high, and ready is high exactly when the queue is not full. A producer that keeps valid high while ready is low loses that beat: the word is dropped and a sticky overflow bit is set. That bit stays set until reset. A read beat is taken when valid and ready are both high. Read data is shown ahead, so the head word is on the data pins whenever valid is high. A consumer that raises ready while valid is low changes nothing. Every core gets its own copy of the bridge.

Control and status pins are plain levels. Everything runs on one clock, and state changes on the rising edge.

Top module: `hcb_bridge`

## Requirements
- R1: After reset both queues are empty and not full. All overflow bits, flags, busy and request outputs are 0, and both interrupt outputs are 0.
- R2: The downlink queue holds DN_DEPTH (8) words and returns them to the core in the order the host wrote them. The full status rises on the 8th accepted word, and h_wr_ready is then low.
- R3: A host write beat while the downlink queue is full is dropped. The queue contents stay unchanged and h_dn_ovf becomes 1 and stays 1 until reset.
- R4: The uplink queue holds UP_DEPTH (4) words and returns them to the host in write order. The full status rises on the 4th accepted word.
- R5: A core write beat while the uplink queue is full is dropped, and c_up_ovf becomes 1 and stays 1.
- R6: c_rx_irq is 1 exactly when the downlink queue holds at least one word and c_rx_ie is 1.
- R7: A c_flag_we pulse loads c_flag_din into the flags. The host sees the new value on h_flag after that clock edge. h_irq is the OR over all bits of h_flag AND h_flag_ie.
- R8: A host command write while no command is pending stores h_cmd_vec. From the next cycle, c_vec_req and h_cmd_busy are 1 and c_vec_num shows the stored number. All three hold until acknowledged.
- R9: c_vec_ack while a command is pending clears the request and busy after that edge. An acknowledge with nothing pending has no effect.
- R10: A host command write while a command is pending is ignored, and the pending vector number is kept.
- R11: A read beat and a write beat on the same queue in the same cycle, with the queue neither empty nor full, keep the occupancy and the word order.
- R12: A read with ready high while the queue is empty changes neither the queue nor its status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr_valid | input | 1 | Host downlink write valid |
| h_wr_data | input | DATA_W | Host downlink write word |
| h_wr_ready | output | 1 | Downlink has room |
| h_rd_valid | output | 1 | Uplink word available to host |
| h_rd_data | output | DATA_W | Uplink head word |
| h_rd_ready | input | 1 | Host takes uplink head |
| h_dn_full | output | 1 | Downlink full (host view) |
| h_dn_empty | output | 1 | Downlink empty (host view) |
| h_up_full | output | 1 | Uplink full (host view) |
| h_up_empty | output | 1 | Uplink empty (host view) |
| h_dn_ovf | output | 1 | Sticky: host write dropped |
| h_cmd_we | input | 1 | Host command vector write strobe |
| h_cmd_vec | input | VEC_W | Vector number to request |
| h_cmd_busy | output | 1 | Command pending |
| h_flag | output | NFLAG | Core flags seen by host |
| h_flag_ie | input | NFLAG | Per-flag host interrupt enable |
| h_irq | output | 1 | Host interrupt |
| c_rd_valid | output | 1 | Downlink word available to core |
| c_rd_data | output | DATA_W | Downlink head word |
| c_rd_ready | input | 1 | Core takes downlink head |
| c_wr_valid | input | 1 | Core uplink write valid |
| c_wr_data | input | DATA_W | Core uplink write word |
| c_wr_ready | output | 1 | Uplink has room |
| c_dn_full | output | 1 | Downlink full (core view) |
| c_dn_empty | output | 1 | Downlink empty (core view) |
| c_up_full | output | 1 | Uplink full (core view) |
| c_up_empty | output | 1 | Uplink empty (core view) |
| c_up_ovf | output | 1 | Sticky: core write dropped |
| c_rx_ie | input | 1 | Core data-available interrupt enable |
| c_rx_irq | output | 1 | Core data-available interrupt |
| c_flag_we | input | 1 | Core flag write strobe |
| c_flag_din | input | NFLAG | New flag value |
| c_vec_req | output | 1 | Vectored interrupt request to core |
| c_vec_num | output | VEC_W | Requested vector number |
| c_vec_ack | input | 1 | Core acknowledges the request |

## Verification
The bench fills each queue one word past its depth. A queue that drops the wrong word, or accepts the extra one, shows up as a wrong read order or a wrong full flag. It posts a second command vector while one is pending. A bridge that overwrites the latch would hand the core the wrong vector number, and one that drops the request early would lower the request before the acknowledge. It also reads from an empty queue, pushes and pops a partly filled queue in the same cycle, and acknowledges when nothing is pending. Each of these catches pointer or count slips that would corrupt occupancy or revive a stale request.

// File: rtl/hcb_pkg.sv
package hcb_pkg;
  typedef struct packed {
    logic full;
    logic empty;
    logic ovf;
  } q_stat_t;
endpackage

// File: rtl/hcb_fifo.sv
module hcb_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  input  logic         rd_ready,
  output hcb_pkg::q_stat_t stat
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          ovf_q;
  logic          push, pop;

  assign wr_ready = (cnt != FULLC);
  assign rd_valid = (cnt != '0);
  assign push     = wr_valid && wr_ready;
  assign pop      = rd_valid && rd_ready;
  assign rd_data  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt   <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (wr_valid && !wr_ready) ovf_q <= 1'b1;
    end
  end

  assign stat.full  = !wr_ready;
  assign stat.empty = !rd_valid;
  assign stat.ovf   = ovf_q;
endmodule

// File: rtl/hcb_cmdvec.sv
module hcb_cmdvec #(
  parameter int VW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [VW-1:0] vec_in,
  input  logic          ack,
  output logic          pending,
  output logic [VW-1:0] vec_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      vec_out <= '0;
    end else if (pending) begin
      if (ack) pending <= 1'b0;
    end else if (wr) begin
      pending <= 1'b1;
      vec_out <= vec_in;
    end
  end
endmodule

// File: rtl/hcb_flags.sv
module hcb_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [N-1:0] din,
  input  logic [N-1:0] ie,
  output logic [N-1:0] flag,
  output logic         irq
);
  logic [N-1:0] hit;

  always_ff @(posedge clk) begin
    if (!rst_n)  flag <= '0;
    else if (we) flag <= din;
  end

  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = flag[i] & ie[i];
  end

  assign irq = |hit;
endmodule

// File: rtl/hcb_bridge.sv
module hcb_bridge #(
  parameter int DATA_W   = 24,
  parameter int DN_DEPTH = 8,
  parameter int UP_DEPTH = 4,
  parameter int VEC_W    = 6,
  parameter int NFLAG    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr_valid,
  input  logic [DATA_W-1:0] h_wr_data,
  output logic              h_wr_ready,
  output logic              h_rd_valid,
  output logic [DATA_W-1:0] h_rd_data,
  input  logic              h_rd_ready,
  output logic              h_dn_full,
  output logic              h_dn_empty,
  output logic              h_up_full,
  output logic              h_up_empty,
  output logic              h_dn_ovf,
  input  logic              h_cmd_we,
  input  logic [VEC_W-1:0]  h_cmd_vec,
  output logic              h_cmd_busy,
  output logic [NFLAG-1:0]  h_flag,
  input  logic [NFLAG-1:0]  h_flag_ie,
  output logic              h_irq,
  output logic              c_rd_valid,
  output logic [DATA_W-1:0] c_rd_data,
  input  logic              c_rd_ready,
  input  logic              c_wr_valid,
  input  logic [DATA_W-1:0] c_wr_data,
  output logic              c_wr_ready,
  output logic              c_dn_full,
  output logic              c_dn_empty,
  output logic              c_up_full,
  output logic              c_up_empty,
  output logic              c_up_ovf,
  input  logic              c_rx_ie,
  output logic              c_rx_irq,
  input  logic              c_flag_we,
  input  logic [NFLAG-1:0]  c_flag_din,
  output logic              c_vec_req,
  output logic [VEC_W-1:0]  c_vec_num,
  input  logic              c_vec_ack
);
  import hcb_pkg::*;

  q_stat_t dn_stat, up_stat;
  logic    pend;

  hcb_fifo #(.W(DATA_W), .DEPTH(DN_DEPTH)) u_dn (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(h_wr_valid), .wr_data(h_wr_data), .wr_ready(h_wr_ready),
    .rd_valid(c_rd_valid), .rd_data(c_rd_data), .rd_ready(c_rd_ready),
    .stat(dn_stat)
  );

  hcb_fifo #(.W(DATA_W), .DEPTH(UP_DEPTH)) u_up (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(c_wr_valid), .wr_data(c_wr_data), .wr_ready(c_wr_ready),
    .rd_valid(h_rd_valid), .rd_data(h_rd_data), .rd_ready(h_rd_ready),
    .stat(up_stat)
  );

  hcb_cmdvec #(.VW(VEC_W)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .wr(h_cmd_we), .vec_in(h_cmd_vec), .ack(c_vec_ack),
    .pending(pend), .vec_out(c_vec_num)
  );

  hcb_flags #(.N(NFLAG)) u_flg (
    .clk(clk), .rst_n(rst_n),
    .we(c_flag_we), .din(c_flag_din), .ie(h_flag_ie),
    .flag(h_flag), .irq(h_irq)
  );

  assign h_dn_full  = dn_stat.full;
  assign h_dn_empty = dn_stat.empty;
  assign c_dn_full  = dn_stat.full;
  assign c_dn_empty = dn_stat.empty;
  assign h_dn_ovf   = dn_stat.ovf;
  assign h_up_full  = up_stat.full;
  assign h_up_empty = up_stat.empty;
  assign c_up_full  = up_stat.full;
  assign c_up_empty = up_stat.empty;
  assign c_up_ovf   = up_stat.ovf;
  assign c_rx_irq   = c_rx_ie && !dn_stat.empty;
  assign c_vec_req  = pend;
  assign h_cmd_busy = pend;
endmodule

// File: rtl/hcb_bridge_chk.sv
module hcb_bridge_chk #(
  parameter int VEC_W = 6,
  parameter int NFLAG = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             h_wr_ready,
  input logic             c_dn_full,
  input logic             h_dn_ovf,
  input logic             c_up_ovf,
  input logic             c_rd_valid,
  input logic             c_rx_irq,
  input logic             c_rx_ie,
  input logic             h_irq,
  input logic [NFLAG-1:0] h_flag,
  input logic [NFLAG-1:0] h_flag_ie,
  input logic             c_vec_req,
  input logic             c_vec_ack,
  input logic [VEC_W-1:0] c_vec_num,
  input logic             h_cmd_busy
);
  a_r2_no_ready_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    c_dn_full |-> !h_wr_ready);
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    h_dn_ovf |=> h_dn_ovf);
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    c_up_ovf |=> c_up_ovf);
  a_r6_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    c_rx_irq |-> (c_rd_valid && c_rx_ie));
  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    h_irq |-> |(h_flag & h_flag_ie));
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (c_vec_req && !c_vec_ack) |=> (c_vec_req && $stable(c_vec_num)));
  a_r8_busy_mirrors_req: assert property (@(posedge clk) disable iff (!rst_n)
    h_cmd_busy == c_vec_req);
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (c_vec_req && c_vec_ack) |=> !c_vec_req);
endmodule

bind hcb_bridge hcb_bridge_chk #(.VEC_W(VEC_W), .NFLAG(NFLAG)) u_chk (.*);

// File: tb/tb_hcb_bridge.sv
module tb_hcb_bridge;
  localparam int DW = 24;
  localparam int VW = 6;
  localparam int NF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic h_wr_valid = 0, h_rd_ready = 0, h_cmd_we = 0;
  logic [DW-1:0] h_wr_data = '0;
  logic [VW-1:0] h_cmd_vec = '0;
  logic [NF-1:0] h_flag_ie = '0;
  logic c_rd_ready = 0, c_wr_valid = 0, c_rx_ie = 0, c_flag_we = 0, c_vec_ack = 0;
  logic [DW-1:0] c_wr_data = '0;
  logic [NF-1:0] c_flag_din = '0;
  logic h_wr_ready, h_rd_valid, h_dn_full, h_dn_empty, h_up_full, h_up_empty, h_dn_ovf;
  logic h_cmd_busy, h_irq, c_rd_valid, c_wr_ready, c_dn_full, c_dn_empty;
  logic c_up_full, c_up_empty, c_up_ovf, c_rx_irq, c_vec_req;
  logic [DW-1:0] h_rd_data, c_rd_data;
  logic [NF-1:0] h_flag;
  logic [VW-1:0] c_vec_num;

  hcb_bridge dut (.*);

  int checks = 0;
  int fails  = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {op(1=pop), data, exp_full_after, exp_empty_after}
  localparam logic [26:0] TBL [17] = '{
    {1'b0, 24'h000A01, 1'b0, 1'b0}, {1'b0, 24'h000A02, 1'b0, 1'b0},
    {1'b0, 24'h000A03, 1'b0, 1'b0}, {1'b0, 24'h000A04, 1'b0, 1'b0},
    {1'b0, 24'h000A05, 1'b0, 1'b0}, {1'b0, 24'h000A06, 1'b0, 1'b0},
    {1'b0, 24'h000A07, 1'b0, 1'b0}, {1'b0, 24'h000A08, 1'b1, 1'b0},
    {1'b0, 24'h0000FF, 1'b1, 1'b0},
    {1'b1, 24'h000A01, 1'b0, 1'b0}, {1'b1, 24'h000A02, 1'b0, 1'b0},
    {1'b1, 24'h000A03, 1'b0, 1'b0}, {1'b1, 24'h000A04, 1'b0, 1'b0},
    {1'b1, 24'h000A05, 1'b0, 1'b0}, {1'b1, 24'h000A06, 1'b0, 1'b0},
    {1'b1, 24'h000A07, 1'b0, 1'b0}, {1'b1, 24'h000A08, 1'b0, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 dn_empty", {h_dn_empty, c_dn_empty, h_dn_full}, 3'b110);
    check("R1 up_empty", {h_up_empty, c_up_empty, c_up_full}, 3'b110);
    check("R1 misc", {h_dn_ovf, c_up_ovf, h_cmd_busy, c_vec_req, h_irq, c_rx_irq, h_flag}, '0);

    // R2/R3 downlink via table
    for (int i = 0; i < 17; i++) begin
      logic [26:0] e;
      e = TBL[i];
      if (e[26]) begin
        check("R2 order", c_rd_data, e[25:2]);
        c_rd_ready = 1;
      end else begin
        h_wr_valid = 1;
        h_wr_data  = e[25:2];
      end
      @(negedge clk);
      c_rd_ready = 0; h_wr_valid = 0;
      check("R2 full", c_dn_full, e[1]);
      check("R2 empty", c_dn_empty, e[0]);
      if (i == 8) check("R3 ovf", h_dn_ovf, 1);
    end
    check("R3 ovf sticky", h_dn_ovf, 1);

    // R12 pop on empty
    c_rd_ready = 1; @(negedge clk); c_rd_ready = 0;
    check("R12 still empty", {c_dn_empty, c_dn_full, c_rd_valid}, 3'b100);
    h_wr_valid = 1; h_wr_data = 24'h123456; @(negedge clk); h_wr_valid = 0;
    check("R12 next word intact", c_rd_data, 24'h123456);

    // R6 rx irq
    check("R6 irq disabled", c_rx_irq, 0);
    c_rx_ie = 1; #1;
    check("R6 irq enabled", c_rx_irq, 1);
    // R11 simultaneous push/pop on downlink (1 word inside)
    h_wr_valid = 1; h_wr_data = 24'h654321; c_rd_ready = 1;
    @(negedge clk); h_wr_valid = 0; c_rd_ready = 0;
    check("R11 head", c_rd_data, 24'h654321);
    check("R11 count", {c_rd_valid, c_dn_full}, 2'b10);
    c_rd_ready = 1; @(negedge clk); c_rd_ready = 0;
    check("R11 drained", c_dn_empty, 1);
    check("R6 irq off when empty", c_rx_irq, 0);
    c_rx_ie = 0;

    // R4/R5 uplink
    for (int i = 0; i < 5; i++) begin
      c_wr_valid = 1; c_wr_data = 24'hB00 + 24'(i);
      @(negedge clk);
      c_wr_valid = 0;
      check("R4 full", h_up_full, (i >= 3) ? 1 : 0);
    end
    check("R5 ovf", c_up_ovf, 1);
    for (int i = 0; i < 4; i++) begin
      check("R4 order", h_rd_data, 24'hB00 + 24'(i));
      h_rd_ready = 1; @(negedge clk); h_rd_ready = 0;
    end
    check("R4 empty", {h_up_empty, h_rd_valid}, 2'b10);
    check("R5 ovf sticky", c_up_ovf, 1);

    // R7 flags
    c_flag_din = 2'b10; c_flag_we = 1; #1;
    check("R7 not yet", h_flag, 2'b00);
    @(negedge clk); c_flag_we = 0;
    check("R7 flag", h_flag, 2'b10);
    h_flag_ie = 2'b01; #1;
    check("R7 irq masked", h_irq, 0);
    h_flag_ie = 2'b10; #1;
    check("R7 irq", h_irq, 1);
    h_flag_ie = 2'b00;

    // R9 ack while idle
    c_vec_ack = 1; @(negedge clk); c_vec_ack = 0;
    check("R9 idle ack", {c_vec_req, h_cmd_busy}, 2'b00);
    // R8 command
    h_cmd_we = 1; h_cmd_vec = 6'd37; #1;
    check("R8 not yet", c_vec_req, 0);
    @(negedge clk); h_cmd_we = 0;
    check("R8 req", {c_vec_req, h_cmd_busy}, 2'b11);
    check("R8 num", c_vec_num, 37);
    repeat (3) @(negedge clk);
    check("R8 held", c_vec_req, 1);
    // R10 overwrite ignored
    h_cmd_we = 1; h_cmd_vec = 6'd9; @(negedge clk); h_cmd_we = 0;
    check("R10 kept", c_vec_num, 37);
    check("R10 busy", h_cmd_busy, 1);
    // R9 ack
    c_vec_ack = 1; @(negedge clk); c_vec_ack = 0;
    check("R9 cleared", {c_vec_req, h_cmd_busy}, 2'b00);
    h_cmd_we = 1; h_cmd_vec = 6'd9; @(negedge clk); h_cmd_we = 0;
    check("R8 new num", {c_vec_req, 26'(c_vec_num)}, {1'b1, 26'd9});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule